// File: doc/BRIEF.md
# Dual-Phase Stepper Pulse Shaper

This block converts single-cycle event strobes into the pulse waveforms that drive a metering display. Each strobe on the slow path becomes one active-low pulse on one of two phase outputs. Successive strobes go to the two phases in turn, so a two-phase stepper motor or an impulse counter advances once per event. Each strobe on the fast path becomes one active-high pulse on a single calibration output. All outputs are registered and change only on clock edges.

Each path measures the spacing between its own strobes. While events are sparse, the pulse width is a long fixed value. When events crowd together, the width shrinks to fit the measured spacing, so that pulses stay distinct. The slow path also keeps a minimum idle gap between the end of one phase and the start of the other. If a strobe arrives before that gap has passed, its start is held until the gap is met. Widths, period thresholds and the gap are given in clock ticks. They are parameters, so a simulation can use short values.

Top module: `stepPulseShaper`

## Requirements
- R1: During and right after reset, f1N and f2N are high and fout is low. The first slow strobe after reset goes to f1N.
- R2: A slow strobe sampled on a clock edge drives its phase low from that edge onward. The low time is SLOW_WIDTH cycles when no earlier slow strobe has been seen since reset, or when twice the spacing to the previous slow strobe is at least SLOW_SPAN.
- R3: When twice the spacing to the previous slow strobe is below SLOW_SPAN, the slow pulse lasts the spacing minus GUARD cycles, and never less than 1 cycle.
- R4: Slow strobes are steered alternately to f1N and f2N. For evenly spaced strobes, the falling edge of f2N follows the falling edge of f1N by one strobe spacing.
- R5: f1N and f2N are never low together. Between the end of a pulse on one phase and the start of a pulse on the other, both phases stay high for at least GUARD cycles. A start that this gap blocks is issued on the first edge that satisfies the gap, and it keeps the width computed for its own strobe.
- R6: A fast strobe drives fout high for FAST_WIDTH cycles when no earlier fast strobe has been seen since reset, or when the spacing to the previous fast strobe is at least FAST_SPAN.
- R7: When the spacing to the previous fast strobe is below FAST_SPAN, the fout pulse lasts half the spacing, rounded down, and never less than 1 cycle.
- R8: A strobe that arrives while its own output is still active reloads that output. The pulse then lasts the newly computed width, counted from the new strobe's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| slowEvt | input | 1 | Single-cycle strobe for the two-phase low-rate output |
| fastEvt | input | 1 | Single-cycle strobe for the calibration output |
| f1N | output | 1 | Phase one, active-low pulse |
| f2N | output | 1 | Phase two, active-low pulse |
| fout | output | 1 | Calibration output, active-high pulse |

## Verification
The bench builds the shaper with SLOW_WIDTH 20, SLOW_SPAN 40, FAST_WIDTH 6, FAST_SPAN 12 and GUARD 4. With these values, the change from fixed width to spacing-derived width happens within a few tens of cycles. A slow spacing of exactly 20 makes one phase end on the very edge where the other phase's strobe arrives, which exercises the held start and its four-cycle delay. Fast spacings of 2 to 5 fall inside a running pulse, which exercises the reload rule and the one-cycle floor.

// File: rtl/stepShaperPkg.sv
package stepShaperPkg;

  // Output channel indices
  localparam int CH_F1   = 0;
  localparam int CH_F2   = 1;
  localparam int CH_FAST = 2;
  localparam int NUM_CH  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] load;     // start or reload a pulse on a channel
    logic [1:0]        usePend;  // phase start takes the held width
    logic [1:0]        capture;  // phase start blocked: keep the current width
  } shaperCtl_t;

endpackage

// File: rtl/intervalMeter.sv
module intervalMeter #(
  parameter int SPAN       = 40,
  parameter int LONG_WIDTH = 20,
  parameter int PHASES     = 2,
  parameter int TRIM       = 4,
  parameter int WID_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evt,
  output logic [WID_W-1:0] width
);

  localparam int CNT_W = $clog2(SPAN + 1);
  localparam int PW    = CNT_W + $clog2(PHASES + 1);

  logic [CNT_W-1:0] since;
  logic             seen;
  logic [PW-1:0]    period;
  logic [PW-1:0]    half;
  logic             isShort;

  // Cycles since the previous strobe, saturating at SPAN
  always_ff @(posedge clk) begin
    if (!rstN) begin
      since <= CNT_W'(SPAN);
      seen  <= 1'b0;
    end else if (evt) begin
      since <= CNT_W'(1);
      seen  <= 1'b1;
    end else if (since != CNT_W'(SPAN)) begin
      since <= since + 1'b1;
    end
  end

  // Output period is the strobe spacing times the number of phases
  assign period  = PW'(since) * PW'(PHASES);
  assign half    = period >> 1;
  assign isShort = seen && (period < PW'(SPAN));

  always_comb begin
    if (!isShort)
      width = WID_W'(LONG_WIDTH);
    else if (half > PW'(TRIM))
      width = WID_W'(half - PW'(TRIM));
    else
      width = WID_W'(1);
  end

endmodule

// File: rtl/shaperControl.sv
module shaperControl
  import stepShaperPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowEvt,
  input  logic       fastEvt,
  input  logic [1:0] clear,
  output shaperCtl_t ctl
);

  logic       toF2;
  logic [1:0] pend;
  logic [1:0] evt;
  logic [1:0] want;
  logic [1:0] go;

  // The steering flop picks the phase for each slow strobe
  assign evt  = {slowEvt && toF2, slowEvt && !toF2};
  assign want = evt | pend;

  // A phase may start only once the other phase has been quiet long enough
  assign go[CH_F1] = want[CH_F1] && clear[CH_F2];
  assign go[CH_F2] = want[CH_F2] && clear[CH_F1] && !go[CH_F1];

  always_comb begin
    ctl.load    = {fastEvt, go};
    ctl.usePend = go & ~evt;
    ctl.capture = evt & ~go;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toF2 <= 1'b0;
      pend <= '0;
    end else begin
      toF2 <= toF2 ^ slowEvt;
      pend <= want & ~go;
    end
  end

  // A held start must leave the pending state on the edge it is issued
  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.usePend[CH_F1] |=> !pend[CH_F1]);  // R5

endmodule

// File: rtl/shaperDatapath.sv
module shaperDatapath
  import stepShaperPkg::*;
#(
  parameter int SLOW_WIDTH = 20,
  parameter int SLOW_SPAN  = 40,
  parameter int FAST_WIDTH = 6,
  parameter int FAST_SPAN  = 12,
  parameter int GUARD      = 4,
  parameter int WID_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowEvt,
  input  logic              fastEvt,
  input  shaperCtl_t        ctl,
  output logic [NUM_CH-1:0] active,
  output logic [1:0]        clear
);

  localparam int Q_W = $clog2(GUARD + 1);

  logic [WID_W-1:0] slowWidth;
  logic [WID_W-1:0] fastWidth;
  logic [1:0]       quietFull;

  intervalMeter #(
    .SPAN(SLOW_SPAN), .LONG_WIDTH(SLOW_WIDTH), .PHASES(2), .TRIM(GUARD), .WID_W(WID_W)
  ) u_slowMeter (
    .clk(clk), .rstN(rstN), .evt(slowEvt), .width(slowWidth)
  );

  intervalMeter #(
    .SPAN(FAST_SPAN), .LONG_WIDTH(FAST_WIDTH), .PHASES(1), .TRIM(0), .WID_W(WID_W)
  ) u_fastMeter (
    .clk(clk), .rstN(rstN), .evt(fastEvt), .width(fastWidth)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WID_W-1:0] remain;
    logic [WID_W-1:0] loadVal;

    if (c == CH_FAST) begin : g_fast
      assign loadVal = fastWidth;
    end else begin : g_phase
      logic [WID_W-1:0] heldWidth;
      logic [Q_W-1:0]   quiet;

      assign loadVal = ctl.usePend[c] ? heldWidth : slowWidth;

      always_ff @(posedge clk) begin
        if (!rstN)
          heldWidth <= '0;
        else if (ctl.capture[c])
          heldWidth <= slowWidth;
      end

      // Consecutive idle cycles of this phase, saturating at GUARD
      always_ff @(posedge clk) begin
        if (!rstN)
          quiet <= Q_W'(GUARD);
        else if (active[c])
          quiet <= '0;
        else if (quiet != Q_W'(GUARD))
          quiet <= quiet + 1'b1;
      end

      assign clear[c]     = !active[c] && (quiet >= Q_W'(GUARD - 1));
      assign quietFull[c] = (quiet == Q_W'(GUARD));
    end

    // Remaining pulse cycles; a load always restarts the count
    always_ff @(posedge clk) begin
      if (!rstN)
        remain <= '0;
      else if (ctl.load[c])
        remain <= loadVal;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end

    assign active[c] = (remain != '0);

    AST_LOAD_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
      ctl.load[c] |=> active[c]);  // R8
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(active[CH_F1] && active[CH_F2]));  // R5

  AST_GUARD_F1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active[CH_F1]) |-> quietFull[CH_F2]);  // R5

  AST_GUARD_F2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active[CH_F2]) |-> quietFull[CH_F1]);  // R5

  AST_FAST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active[CH_FAST]) |-> $past(fastEvt));  // R6

endmodule

// File: rtl/stepPulseShaper.sv
module stepPulseShaper
  import stepShaperPkg::*;
#(
  parameter int SLOW_WIDTH = 984_500,    // 275 ms at 3.58 MHz
  parameter int SLOW_SPAN  = 1_969_000,  // 550 ms
  parameter int FAST_WIDTH = 322_200,    // 90 ms
  parameter int FAST_SPAN  = 644_400,    // 180 ms
  parameter int GUARD      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowEvt,
  input  logic fastEvt,
  output logic f1N,
  output logic f2N,
  output logic fout
);

  localparam int WID_W = $clog2(SLOW_WIDTH + SLOW_SPAN + FAST_WIDTH + FAST_SPAN + 1);

  shaperCtl_t        ctl;
  logic [NUM_CH-1:0] active;
  logic [1:0]        clear;

  shaperControl u_ctrl (
    .clk(clk), .rstN(rstN), .slowEvt(slowEvt), .fastEvt(fastEvt),
    .clear(clear), .ctl(ctl)
  );

  shaperDatapath #(
    .SLOW_WIDTH(SLOW_WIDTH), .SLOW_SPAN(SLOW_SPAN),
    .FAST_WIDTH(FAST_WIDTH), .FAST_SPAN(FAST_SPAN),
    .GUARD(GUARD), .WID_W(WID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .slowEvt(slowEvt), .fastEvt(fastEvt),
    .ctl(ctl), .active(active), .clear(clear)
  );

  assign f1N  = !active[CH_F1];
  assign f2N  = !active[CH_F2];
  assign fout = active[CH_FAST];

endmodule

// File: tb/test_stepPulseShaper.sv
module test_stepPulseShaper;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 4;
  localparam int SW         = 20;
  localparam int FW         = 6;
  // {spacing, expected width of the second pulse}
  localparam int FAST_VEC [7][2] = '{'{20, 6}, '{12, 6}, '{11, 5}, '{8, 4},
                                     '{5, 2}, '{3, 1}, '{2, 1}};

  logic clk = 1'b0;
  logic rstN;
  logic slowEvt;
  logic fastEvt;
  logic f1N, f2N, fout;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Monitor state
  int cyc = 0;
  int run1 = 0, run2 = 0;
  int w1 = 0, w2 = 0;
  int fall1 = 0, fall2 = 0;
  int nF1 = 0, nF2 = 0;
  int idleBoth = 0;
  int lastOwner = 0;
  int lastGap = -1;
  int minGap = 1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepPulseShaper #(
    .SLOW_WIDTH(SW), .SLOW_SPAN(40), .FAST_WIDTH(FW), .FAST_SPAN(12), .GUARD(GUARD)
  ) i_stepPulseShaper (
    .clk(clk), .rstN(rstN), .slowEvt(slowEvt), .fastEvt(fastEvt),
    .f1N(f1N), .f2N(f2N), .fout(fout)
  );

  always @(negedge clk) begin
    cyc++;
    if (!f1N) begin
      if (run1 == 0) begin
        fall1 = cyc; nF1++;
        if (lastOwner == 2) begin
          lastGap = idleBoth;
          if (idleBoth < minGap) minGap = idleBoth;
        end
        lastOwner = 1; idleBoth = 0;
      end
      run1++;
    end else if (run1 != 0) begin
      w1 = run1; run1 = 0;
    end
    if (!f2N) begin
      if (run2 == 0) begin
        fall2 = cyc; nF2++;
        if (lastOwner == 1) begin
          lastGap = idleBoth;
          if (idleBoth < minGap) minGap = idleBoth;
        end
        lastOwner = 2; idleBoth = 0;
      end
      run2++;
    end else if (run2 != 0) begin
      w2 = run2; run2 = 0;
    end
    if (f1N && f2N) idleBoth++;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic slowTrain(int n, int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); slowEvt = 1'b1;
      @(negedge clk); slowEvt = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  task automatic fastPair(int d, output int w);
    @(negedge clk); fastEvt = 1'b1;
    @(negedge clk); fastEvt = 1'b0;
    repeat (d - 1) @(negedge clk);
    fastEvt = 1'b1;
    @(negedge clk); fastEvt = 1'b0;
    w = 0;
    while (fout === 1'b1 && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int w;
    rstN = 1'b0; slowEvt = 1'b0; fastEvt = 1'b0;
    idle(5);
    check("R1 f1N in reset", int'(f1N), 1);
    check("R1 f2N in reset", int'(f2N), 1);
    check("R1 fout in reset", int'(fout), 0);
    rstN = 1'b1;
    idle(3);
    check("R1 outputs idle after reset", int'({f1N, f2N, fout}), 6);

    // First slow strobe: goes to F1 with the long width
    slowTrain(1, 2); idle(40);
    check("R1 first pulse on F1", nF1, 1);
    check("R1 F2 untouched by first strobe", nF2, 0);
    check("R2 long width on first strobe", w1, SW);

    // Second strobe alternates to F2
    slowTrain(1, 2); idle(40);
    check("R4 second strobe on F2", nF2, 1);
    check("R2 F2 long width", w2, SW);

    // Dense train, spacing 10: width = 10 - GUARD
    slowTrain(6, 10); idle(40);
    check("R3 short width F1", w1, 10 - GUARD);
    check("R3 short width F2", w2, 10 - GUARD);
    check("R4 F2 fall follows F1 by spacing", fall2 - fall1, 10);

    // Spacing 20: F1 ends on the F2 strobe edge, so the F2 start is held for GUARD
    slowTrain(2, 20); idle(60);
    check("R5 held start delay", fall2 - fall1, 20 + GUARD);
    check("R5 idle gap at held start", lastGap, GUARD);
    check("R5 held start keeps its width", w2, SW);

    // Spacing 30: above threshold, long width, no delay
    slowTrain(2, 30); idle(60);
    check("R4 F2 fall follows F1 by spacing (long)", fall2 - fall1, 30);
    check("R2 long width above threshold", w2, SW);
    check("R5 minimum idle gap seen", int'(minGap >= GUARD), 1);
    check("R5 phases never both low", int'(f1N && f2N), 1);

    // Fast path table
    for (int i = 0; i < 7; i++) begin
      string tag;
      idle(60);
      fastPair(FAST_VEC[i][0], w);
      tag = (FAST_VEC[i][1] == FW) ? "R6" : ((FAST_VEC[i][0] == 5) ? "R8" : "R7");
      if (tag != "R6") total += 0;
      check({tag, " fast width at given spacing"}, w, FAST_VEC[i][1]);
    end

    // Directed: reset restores steering and the long fast width
    idle(20);
    rstN = 1'b0; idle(3); rstN = 1'b1; idle(2);
    begin
      int before1, before2;
      before1 = nF1; before2 = nF2;
      slowTrain(1, 2); idle(40);
      check("R1 first strobe after reset on F1", nF1 - before1, 1);
      check("R1 F2 untouched after reset", nF2 - before2, 0);
    end
    @(negedge clk); fastEvt = 1'b1;
    @(negedge clk); fastEvt = 1'b0;
    w = 0;
    while (fout === 1'b1 && w < 100) begin
      w++;
      @(negedge clk);
    end
    check("R6 first fast pulse after reset", w, FW);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule